// File: doc/BRIEF.md
# Sliding Register Window Mapper

This block turns logical floating-point register numbers into physical slots of a 160-entry register file. The bottom 128 physical slots hold an unshifted prefix whose size software picks, followed by a rotating region. The top 32 slots form a global bank that the window never moves. Logical numbers above the prefix are offset by a base value and wrap around inside the rotating region. A loop body can therefore step the base to reach new registers without renaming them.

Two read ports and one write port are translated each cycle. Translation is purely combinational. Only the prefix size and the base are held in flops. The base changes only through three control commands: load a prefix size, load a base, and advance the base by a step. A small register-file model sits behind the translators, so that write-then-read behaviour can be checked end to end.

Top module: `srw_mapper`

## Requirements
- R1: A port access is legal only when its logical index is below 160 and either its extended qualifier is 1 or the index is below 32. An illegal access drives its ok output 0 and its physical index 0.
- R2: The prefix size is 4 << sel. The fixed_sel_i codes 0, 1, 2 and 3 select 4, 8, 16 and 32 registers. A legal logical index below the prefix size maps to the same physical index.
- R3: A legal logical index L with F <= L < 128 maps to F + ((L - F + base) mod (128 - F)), where F is the prefix size.
- R4: A legal logical index from 128 to 159 maps to the same physical index, whatever the base is.
- R5: set_base_i loads base_val_i mod (128 - F) into the base at the next clock edge. Translations in the same cycle still use the old base.
- R6: adv_base_i replaces the base with (base + base_step_i) mod (128 - F) at the next clock edge.
- R7: set_fixed_i loads the prefix selection and clears the base to 0. Commands rank set_fixed_i, then set_base_i, then adv_base_i, and only the highest-ranked command that is asserted acts.
- R8: While rst_ni is low, the prefix size is 32, the base is 0 and every register-file entry is 0.
- R9: Both read ports and the write port translate independently in the same cycle.
- R10: A write with wr_en_i stores wr_data_i at the translated physical slot at the clock edge, and only when the write access is legal. A read returns the slot content combinationally, so a write in the same cycle is not yet visible.
- R11: Without a command, the base and the prefix size hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| set_fixed_i | input | 1 | Load prefix size selection |
| fixed_sel_i | input | 2 | Prefix size code (4 << code) |
| set_base_i | input | 1 | Load base |
| base_val_i | input | 7 | Base value to load |
| adv_base_i | input | 1 | Advance base |
| base_step_i | input | 7 | Advance step |
| rd_idx_i | input | 2x8 | Logical index per read port |
| rd_ext_i | input | 2 | Extended qualifier per read port |
| rd_phys_o | output | 2x8 | Physical index per read port |
| rd_ok_o | output | 2 | Legal access per read port |
| rd_data_o | output | 2x64 | Register content per read port |
| wr_en_i | input | 1 | Write request |
| wr_idx_i | input | 8 | Logical write index |
| wr_ext_i | input | 1 | Extended qualifier for the write |
| wr_data_i | input | 64 | Write data |
| wr_phys_o | output | 8 | Physical write index |
| wr_ok_o | output | 1 | Write access legal |

## Verification
Two sets of actions can fall in the same cycle. A base command can coincide with a translation, and a write can coincide with a read of the same slot. The stimulus table issues set_base and advance commands in the same cycle as a read check. It expects the mapping computed from the old base, and then the new mapping one cycle later. Directed cases write a logical register and read it back in that same cycle, expecting the old content. A read after the edge must see the new data. Both the bench and the assertions also exercise commands that collide with each other, judging them by the ranking in R7.

// File: rtl/srw_pkg.sv
package srw_pkg;
  localparam int unsigned NUM_PHYS   = 160;
  localparam int unsigned SLIDE_SPAN = 128;
  localparam int unsigned ORD_LIMIT  = 32;
  localparam int unsigned MIN_FIXED  = 4;
  localparam int unsigned FSEL_W     = 2;
  localparam int unsigned DATA_W     = 64;
  localparam int unsigned NUM_RD     = 2;

  typedef enum logic [FSEL_W-1:0] {
    FIX_4  = 2'd0,
    FIX_8  = 2'd1,
    FIX_16 = 2'd2,
    FIX_32 = 2'd3
  } fix_sel_e;
endpackage

// File: rtl/srw_ctrl.sv
module srw_ctrl import srw_pkg::*; #(
  parameter int unsigned SPAN   = SLIDE_SPAN,
  parameter int unsigned FMIN   = MIN_FIXED,
  parameter int unsigned SEL_W  = FSEL_W,
  parameter int unsigned IDX_W  = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     set_fixed_i,
  input  logic [SEL_W-1:0]         fixed_sel_i,
  input  logic                     set_base_i,
  input  logic [$clog2(SPAN)-1:0]  base_val_i,
  input  logic                     adv_base_i,
  input  logic [$clog2(SPAN)-1:0]  base_step_i,
  output logic [IDX_W-1:0]         fixed_size_o,
  output logic [$clog2(SPAN)-1:0]  base_o
);
  localparam int unsigned BASE_W    = $clog2(SPAN);
  localparam int unsigned SUM_W     = BASE_W + 1;
  localparam int unsigned FMAX      = FMIN << ((1 << SEL_W) - 1);
  localparam int unsigned MOD_STEPS = (2 * SPAN) / (SPAN - FMAX) + 1;

  logic [SEL_W-1:0]  sel_q, sel_d;
  logic [BASE_W-1:0] base_q, base_d;
  logic [SUM_W-1:0]  span;

  // reduce by repeated subtraction; bounded by the smallest span
  function automatic logic [BASE_W-1:0] wrap_span(input logic [SUM_W-1:0] v,
                                                  input logic [SUM_W-1:0] s);
    logic [SUM_W-1:0] r;
    r = v;
    for (int i = 0; i < MOD_STEPS; i++) begin
      if (r >= s) r = r - s;
    end
    return r[BASE_W-1:0];
  endfunction

  assign fixed_size_o = IDX_W'(FMIN) << sel_q;
  assign span         = SUM_W'(SPAN) - SUM_W'(fixed_size_o);
  assign base_o       = base_q;

  always_comb begin
    sel_d  = sel_q;
    base_d = base_q;
    if (set_fixed_i) begin
      sel_d  = fixed_sel_i;
      base_d = '0;
    end else if (set_base_i) begin
      base_d = wrap_span({1'b0, base_val_i}, span);
    end else if (adv_base_i) begin
      base_d = wrap_span(SUM_W'(base_q) + SUM_W'(base_step_i), span);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= SEL_W'(FIX_32);
      base_q <= '0;
    end else begin
      sel_q  <= sel_d;
      base_q <= base_d;
    end
  end
endmodule

// File: rtl/srw_xlate.sv
module srw_xlate import srw_pkg::*; #(
  parameter int unsigned PHYS  = NUM_PHYS,
  parameter int unsigned SPAN  = SLIDE_SPAN,
  parameter int unsigned ORD   = ORD_LIMIT,
  parameter int unsigned IDX_W = $clog2(PHYS)
) (
  input  logic [IDX_W-1:0]        idx_i,
  input  logic                    ext_i,
  input  logic [IDX_W-1:0]        fixed_size_i,
  input  logic [$clog2(SPAN)-1:0] base_i,
  output logic [IDX_W-1:0]        phys_o,
  output logic                    ok_o
);
  localparam int unsigned W = IDX_W + 1;

  logic         in_range, in_global, in_fixed;
  logic [W-1:0] win, off, off_w;

  assign in_range  = W'(idx_i) < W'(PHYS);
  assign in_global = W'(idx_i) >= W'(SPAN);
  assign in_fixed  = idx_i < fixed_size_i;
  assign ok_o      = in_range && (ext_i || (W'(idx_i) < W'(ORD)));

  assign win   = W'(SPAN) - W'(fixed_size_i);
  assign off   = W'(idx_i) - W'(fixed_size_i) + W'(base_i);
  assign off_w = (off >= win) ? off - win : off;

  always_comb begin
    if (!ok_o)                       phys_o = '0;
    else if (in_global || in_fixed)  phys_o = idx_i;
    else                             phys_o = fixed_size_i + off_w[IDX_W-1:0];
  end
endmodule

// File: rtl/srw_regfile.sv
module srw_regfile import srw_pkg::*; #(
  parameter int unsigned PHYS  = NUM_PHYS,
  parameter int unsigned DW    = DATA_W,
  parameter int unsigned NRD   = NUM_RD,
  parameter int unsigned IDX_W = $clog2(PHYS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NRD-1:0][IDX_W-1:0] rd_addr_i,
  output logic [NRD-1:0][DW-1:0]    rd_data_o,
  input  logic                      wr_en_i,
  input  logic [IDX_W-1:0]          wr_addr_i,
  input  logic [DW-1:0]             wr_data_i
);
  logic [DW-1:0] mem_q [PHYS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(PHYS); i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      mem_q[wr_addr_i] <= wr_data_i;
    end
  end

  for (genvar p = 0; p < int'(NRD); p++) begin : g_rd
    assign rd_data_o[p] = (32'(rd_addr_i[p]) < PHYS) ? mem_q[rd_addr_i[p]] : '0;
  end
endmodule

// File: rtl/srw_mapper.sv
module srw_mapper import srw_pkg::*; #(
  parameter int unsigned PHYS  = NUM_PHYS,
  parameter int unsigned SPAN  = SLIDE_SPAN,
  parameter int unsigned ORD   = ORD_LIMIT,
  parameter int unsigned FMIN  = MIN_FIXED,
  parameter int unsigned SEL_W = FSEL_W,
  parameter int unsigned DW    = DATA_W,
  parameter int unsigned NRD   = NUM_RD,
  localparam int unsigned IDX_W  = $clog2(PHYS),
  localparam int unsigned BASE_W = $clog2(SPAN)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      set_fixed_i,
  input  logic [SEL_W-1:0]          fixed_sel_i,
  input  logic                      set_base_i,
  input  logic [BASE_W-1:0]         base_val_i,
  input  logic                      adv_base_i,
  input  logic [BASE_W-1:0]         base_step_i,
  input  logic [NRD-1:0][IDX_W-1:0] rd_idx_i,
  input  logic [NRD-1:0]            rd_ext_i,
  output logic [NRD-1:0][IDX_W-1:0] rd_phys_o,
  output logic [NRD-1:0]            rd_ok_o,
  output logic [NRD-1:0][DW-1:0]    rd_data_o,
  input  logic                      wr_en_i,
  input  logic [IDX_W-1:0]          wr_idx_i,
  input  logic                      wr_ext_i,
  input  logic [DW-1:0]             wr_data_i,
  output logic [IDX_W-1:0]          wr_phys_o,
  output logic                      wr_ok_o
);
  logic [IDX_W-1:0]  fixed_size;
  logic [BASE_W-1:0] base;

  srw_ctrl #(.SPAN(SPAN), .FMIN(FMIN), .SEL_W(SEL_W), .IDX_W(IDX_W)) u_ctrl (
    .clk_i, .rst_ni, .set_fixed_i, .fixed_sel_i, .set_base_i, .base_val_i,
    .adv_base_i, .base_step_i, .fixed_size_o(fixed_size), .base_o(base)
  );

  for (genvar p = 0; p < int'(NRD); p++) begin : g_rd_xl
    srw_xlate #(.PHYS(PHYS), .SPAN(SPAN), .ORD(ORD), .IDX_W(IDX_W)) u_xl (
      .idx_i(rd_idx_i[p]), .ext_i(rd_ext_i[p]), .fixed_size_i(fixed_size),
      .base_i(base), .phys_o(rd_phys_o[p]), .ok_o(rd_ok_o[p])
    );
  end

  srw_xlate #(.PHYS(PHYS), .SPAN(SPAN), .ORD(ORD), .IDX_W(IDX_W)) u_wr_xl (
    .idx_i(wr_idx_i), .ext_i(wr_ext_i), .fixed_size_i(fixed_size),
    .base_i(base), .phys_o(wr_phys_o), .ok_o(wr_ok_o)
  );

  srw_regfile #(.PHYS(PHYS), .DW(DW), .NRD(NRD), .IDX_W(IDX_W)) u_rf (
    .clk_i, .rst_ni, .rd_addr_i(rd_phys_o), .rd_data_o,
    .wr_en_i(wr_en_i && wr_ok_o), .wr_addr_i(wr_phys_o), .wr_data_i
  );
endmodule

// File: rtl/srw_mapper_chk.sv
module srw_mapper_chk #(
  parameter int unsigned PHYS  = 160,
  parameter int unsigned SPAN  = 128,
  parameter int unsigned ORD   = 32,
  parameter int unsigned NRD   = 2,
  parameter int unsigned IDX_W = 8,
  parameter int unsigned BASE_W = 7
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      set_fixed_i,
  input logic                      set_base_i,
  input logic                      adv_base_i,
  input logic [NRD-1:0][IDX_W-1:0] rd_idx_i,
  input logic [NRD-1:0]            rd_ext_i,
  input logic [NRD-1:0][IDX_W-1:0] rd_phys_o,
  input logic [NRD-1:0]            rd_ok_o,
  input logic [IDX_W-1:0]          wr_phys_o,
  input logic                      wr_ok_o,
  input logic [IDX_W-1:0]          fixed_size_i,
  input logic [BASE_W-1:0]         base_i
);
  for (genvar p = 0; p < int'(NRD); p++) begin : g_port
    assert_ord_limit_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_ok_o[p] && !rd_ext_i[p]) |-> (32'(rd_idx_i[p]) < ORD));
    assert_illegal_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_ok_o[p] |-> (rd_phys_o[p] == '0));
    assert_fixed_ident_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_ok_o[p] && rd_idx_i[p] < fixed_size_i) |-> (rd_phys_o[p] == rd_idx_i[p]));
    assert_slide_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_ok_o[p] && rd_idx_i[p] >= fixed_size_i && 32'(rd_idx_i[p]) < SPAN)
      |-> (rd_phys_o[p] >= fixed_size_i && 32'(rd_phys_o[p]) < SPAN));
    assert_global_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_ok_o[p] && 32'(rd_idx_i[p]) >= SPAN) |-> (rd_phys_o[p] == rd_idx_i[p]));
  end

  assert_wr_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ok_o |-> (wr_phys_o == '0));
  assert_fixed_pow2_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(fixed_size_i) == 1);
  assert_base_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(base_i) + 32'(fixed_size_i)) < SPAN);
  assert_fixed_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_fixed_i |=> (base_i == '0));
  assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_fixed_i && !set_base_i && !adv_base_i) |=> ($stable(base_i) && $stable(fixed_size_i)));
endmodule

bind srw_mapper srw_mapper_chk #(
  .PHYS(PHYS), .SPAN(SPAN), .ORD(ORD), .NRD(NRD), .IDX_W(IDX_W), .BASE_W(BASE_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .set_fixed_i(set_fixed_i), .set_base_i(set_base_i),
  .adv_base_i(adv_base_i), .rd_idx_i(rd_idx_i), .rd_ext_i(rd_ext_i),
  .rd_phys_o(rd_phys_o), .rd_ok_o(rd_ok_o), .wr_phys_o(wr_phys_o), .wr_ok_o(wr_ok_o),
  .fixed_size_i(fixed_size), .base_i(base)
);

// File: tb/srw_mapper_tb.sv
module srw_mapper_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 20;

  typedef struct packed {
    logic       sf; logic [1:0] fs;
    logic       sb; logic [6:0] bv;
    logic       ad; logic [6:0] st;
    logic [7:0] idx; logic ext;
    logic       ok; logic [7:0] ph;
  } vec_t;

  // sf fs sb bv ad st idx ext | ok phys ; checks use state before this row's command
  localparam vec_t VECS [NV] = '{
    '{0,0,0,0,0,0,5,0,1,5},         // R2 reset prefix 32, R8
    '{0,0,0,0,0,0,40,0,0,0},        // R1 ordinary limit
    '{0,0,1,10,0,0,40,1,1,40},      // R5 old base still used
    '{0,0,0,0,0,0,40,1,1,50},       // R3 R5
    '{0,0,0,0,0,0,127,1,1,41},      // R3 wrap
    '{0,0,0,0,1,90,130,1,1,130},    // R4 global, R6 advance
    '{0,0,0,0,0,0,32,1,1,36},       // R6 (10+90) mod 96
    '{1,0,0,0,0,0,31,0,1,31},       // R7 prefix -> 4
    '{0,0,1,127,0,0,4,1,1,4},       // R5 load 127 mod 124
    '{0,0,0,0,0,0,126,1,1,5},       // R3 R5 wrap
    '{0,0,0,0,0,0,3,0,1,3},         // R2 prefix 4
    '{0,0,0,0,1,121,10,0,1,13},     // R6
    '{0,0,0,0,0,0,10,0,1,10},       // R6 wraps to 0
    '{1,2,1,50,0,0,159,1,1,159},    // R7 priority, R4
    '{0,0,1,111,0,0,20,0,1,20},     // R7 base cleared
    '{0,0,0,0,0,0,16,0,1,127},      // R3
    '{0,0,0,0,0,0,17,0,1,16},       // R3 wrap
    '{0,0,0,0,0,0,160,1,0,0},       // R1 out of range
    '{0,0,1,5,1,7,15,0,1,15},       // R7 load beats advance
    '{0,0,0,0,0,0,16,0,1,21}        // R7 R11
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic set_fixed_i = 0, set_base_i = 0, adv_base_i = 0;
  logic [1:0] fixed_sel_i = '0;
  logic [6:0] base_val_i = '0, base_step_i = '0;
  logic [1:0][7:0] rd_idx_i = '0;
  logic [1:0] rd_ext_i = '0;
  logic [1:0][7:0] rd_phys_o;
  logic [1:0] rd_ok_o;
  logic [1:0][63:0] rd_data_o;
  logic wr_en_i = 0, wr_ext_i = 0;
  logic [7:0] wr_idx_i = '0;
  logic [63:0] wr_data_i = '0;
  logic [7:0] wr_phys_o;
  logic wr_ok_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  srw_mapper u_dut (.*);

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle_cmds();
    set_fixed_i = 0; set_base_i = 0; adv_base_i = 0; wr_en_i = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R8 reset state
    rd_idx_i[0] = 8'd40; rd_ext_i[0] = 1'b1;
    #(CLK_PERIOD*2 + 2);
    check("R8 phys at reset", rd_phys_o[0], 40);
    check("R8 data at reset", rd_data_o[0], 0);
    @(negedge clk_i); rst_ni = 1'b1;

    for (int v = 0; v < NV; v++) begin
      @(negedge clk_i);
      set_fixed_i = VECS[v].sf; fixed_sel_i = VECS[v].fs;
      set_base_i = VECS[v].sb;  base_val_i = VECS[v].bv;
      adv_base_i = VECS[v].ad;  base_step_i = VECS[v].st;
      rd_idx_i[0] = VECS[v].idx; rd_ext_i[0] = VECS[v].ext;
      #1;
      check($sformatf("vec %0d ok", v), rd_ok_o[0], VECS[v].ok);
      check($sformatf("vec %0d phys", v), rd_phys_o[0], VECS[v].ph);
    end
    @(negedge clk_i); idle_cmds();

    // prefix 16, base 5: R9 three ports at once
    rd_idx_i[0] = 8'd20;  rd_ext_i[0] = 1'b0;
    rd_idx_i[1] = 8'd130; rd_ext_i[1] = 1'b1;
    wr_idx_i = 8'd140; wr_ext_i = 1'b0;
    #1;
    check("R9 port0 phys", rd_phys_o[0], 25);
    check("R9 port1 phys", rd_phys_o[1], 130);
    check("R9 write ok", wr_ok_o, 0);
    check("R1 write phys", wr_phys_o, 0);

    // R10 write then same-cycle read
    @(negedge clk_i);
    wr_en_i = 1; wr_idx_i = 8'd20; wr_ext_i = 0; wr_data_i = 64'hA5A5;
    #1;
    check("R10 same-cycle read old", rd_data_o[0], 0);
    check("R10 write phys", wr_phys_o, 25);
    @(negedge clk_i); wr_en_i = 0;
    #1;
    check("R10 read after write", rd_data_o[0], 64'hA5A5);

    // R10 other logical name of same slot after base change
    @(negedge clk_i); set_base_i = 1; base_val_i = 7'd0;
    @(negedge clk_i); idle_cmds();
    rd_idx_i[1] = 8'd25; rd_ext_i[1] = 1'b0;
    #1;
    check("R10 alias phys", rd_phys_o[1], 25);
    check("R10 alias data", rd_data_o[1], 64'hA5A5);

    // R1 illegal write touches nothing
    @(negedge clk_i);
    wr_en_i = 1; wr_idx_i = 8'd50; wr_ext_i = 0; wr_data_i = 64'h1234;
    @(negedge clk_i); wr_en_i = 0;
    rd_idx_i[0] = 8'd50; rd_ext_i[0] = 1'b1;
    rd_idx_i[1] = 8'd0;  rd_ext_i[1] = 1'b0;
    #1;
    check("R1 illegal write slot 50", rd_data_o[0], 0);
    check("R1 illegal write slot 0", rd_data_o[1], 0);

    // R8 asynchronous reset mid-run
    @(negedge clk_i); rst_ni = 0;
    rd_idx_i[0] = 8'd40; rd_ext_i[0] = 1'b1;
    rd_idx_i[1] = 8'd25; rd_ext_i[1] = 1'b0;
    #1;
    check("R8 phys after reset", rd_phys_o[0], 40);
    check("R8 data cleared", rd_data_o[1], 0);
    @(negedge clk_i); rst_ni = 1;

    // R11 base holds over idle cycles
    @(negedge clk_i); set_base_i = 1; base_val_i = 7'd7;
    @(negedge clk_i); idle_cmds();
    repeat (3) @(negedge clk_i);
    rd_idx_i[0] = 8'd32; rd_ext_i[0] = 1'b1;
    #1;
    check("R11 base held", rd_phys_o[0], 39);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule